// File: doc/BRIEF.md
# Parallel Flash Erase Sequencer

This block erases a parallel NOR flash device from a clocked system. It can erase the whole chip or a single 4 KiB sector. It issues the command writes over an asynchronous flash bus, then polls the device status until the erase settles, fails or runs out of poll attempts. On a failed erase it writes a reset command to the device before it reports the result.

A request is a one-cycle `start_i` strobe. The strobe comes with an operation select and a 20-bit byte address; only the sector field of that address matters, and only for a sector erase. `busy_o` stays high while the request is in progress. When the outcome is known, `done_o` pulses and `result_o` carries `8'h00` for success or `8'hFF` for failure. The result holds until the next outcome.

The flash side drives chip enable, write enable and output enable, all active low. It also drives a 20-bit address and an 8-bit bidirectional data bus. The write setup, the write pulse width and the read access time are set in clock cycles by parameters. A poll ceiling parameter bounds the time spent polling.

Top module: `flash_erase_seq`

## Requirements
- R1: Each erase starts with five command writes in this order: 0xAA to 0x05555, 0x55 to 0x02AAA, 0x80 to 0x05555, 0xAA to 0x05555, then 0x55 to 0x02AAA. For a chip erase (`sector_i`=0) the sixth write is 0x10 to 0x05555.
- R2: For a sector erase (`sector_i`=1) the sixth write is 0x30 to address {`addr_i`[19:12], 12'h000}. The low 12 address bits are ignored.
- R3: In every write cycle, chip enable is low and write enable is high for exactly SETUP_CYC cycles before write enable falls. Write enable then stays low for exactly PULSE_CYC cycles, with the address unchanged. Chip enable stays low, with data still driven, for one more cycle after write enable rises. Write enable and output enable are never low at the same time.
- R4: Every status read holds output enable low for exactly ACCESS_CYC cycles. The block never drives the data bus while output enable is low.
- R5: All status reads use address 0x05555. When bit 6 of a read equals bit 6 of the previous read, the erase has succeeded and the result is 0x00.
- R6: When bit 6 differs between two consecutive reads and bit 5 of the later read is 0, polling goes on. The later read then serves as the previous read for the next comparison.
- R7: When bit 6 differs and bit 5 of the later read is 1, the block makes exactly one fresh pair of reads. If bit 6 matches within that pair, the result is 0x00.
- R8: If bit 6 still differs in that fresh pair, the block writes 0xF0 to 0x05555 and reports 0xFF.
- R9: If neither a match nor a bit-5 timeout has appeared after POLL_LIMIT polling reads, the block writes 0xF0 to 0x05555 and reports 0xFF.
- R10: `done_o` is high for exactly one cycle per request, and `busy_o` is low in that cycle. `result_o` keeps its value after the pulse.
- R11: A `start_i` seen while `busy_o` is low starts a request, and `busy_o` is high in the next cycle. A `start_i` seen while busy has no effect on the command sequence, and no second request follows.
- R12: While reset is asserted and after it is released: `busy_o`=0, `done_o`=0, `result_o`=0x00, and chip enable, write enable and output enable are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request strobe |
| sector_i | input | 1 | Operation select: 1 = sector erase, 0 = chip erase |
| addr_i | input | 20 | Target byte address; bits 19:12 select the sector |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 8 | 0x00 on success, 0xFF on failure |
| fl_addr_o | output | 20 | Flash address bus |
| fl_data_io | inout | 8 | Flash data bus, driven only during write cycles |
| fl_ce_no | output | 1 | Flash chip enable, active low |
| fl_we_no | output | 1 | Flash write enable, active low |
| fl_oe_no | output | 1 | Flash output enable, active low |

## Verification
The bench's flash model toggles bit 6 for a set number of reads and can raise bit 5 from a chosen read onward. From that it counts the exact number of status reads the block should make, so the checks on result and read count cover several cases:
- A design that compares fixed pairs instead of sliding pairs reads too many times.
- A design that skips the recheck reports failure where the fresh pair would have passed.
- A design that ignores the poll ceiling hangs.

A fresh pair that still toggles, and a run that hits the ceiling, must each add a seventh write of 0xF0. The sector case uses addresses with every low bit set to show that the low 12 bits are cleared. A second start strobe in the middle of a chip erase must not change the sixth command byte or start a second request.

// File: rtl/flash_erase_pkg.sv
package flash_erase_pkg;

  localparam int ADDR_W   = 20;
  localparam int DATA_W   = 8;
  localparam int SECT_LSB = 12;
  localparam int SECT_W   = ADDR_W - SECT_LSB;
  localparam int CMD_LAST = 5;

  localparam logic [ADDR_W-1:0] ADR_KEY_A = 20'h05555;
  localparam logic [ADDR_W-1:0] ADR_KEY_B = 20'h02AAA;

  localparam logic [DATA_W-1:0] KEY_HI     = 8'hAA;
  localparam logic [DATA_W-1:0] KEY_LO     = 8'h55;
  localparam logic [DATA_W-1:0] KEY_ERASE  = 8'h80;
  localparam logic [DATA_W-1:0] GO_CHIP    = 8'h10;
  localparam logic [DATA_W-1:0] GO_SECTOR  = 8'h30;
  localparam logic [DATA_W-1:0] DEV_RESET  = 8'hF0;
  localparam logic [DATA_W-1:0] RES_PASS   = 8'h00;
  localparam logic [DATA_W-1:0] RES_FAIL   = 8'hFF;

  localparam int BIT_TOGGLE  = 6;
  localparam int BIT_EXPIRED = 5;

  typedef enum logic [2:0] {
    CTL_IDLE, CTL_CMD, CTL_POLL, CTL_RCHK, CTL_RST
  } ctl_state_e;

  typedef enum logic [2:0] {
    BUS_IDLE, BUS_SETUP, BUS_PULSE, BUS_HOLD, BUS_READ
  } bus_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } bus_word_t;

  function automatic bus_word_t cmd_word(input logic [2:0] step,
                                         input logic sector,
                                         input logic [SECT_W-1:0] sect);
    bus_word_t w;
    case (step)
      3'd0:    w = '{addr: ADR_KEY_A, data: KEY_HI};
      3'd1:    w = '{addr: ADR_KEY_B, data: KEY_LO};
      3'd2:    w = '{addr: ADR_KEY_A, data: KEY_ERASE};
      3'd3:    w = '{addr: ADR_KEY_A, data: KEY_HI};
      3'd4:    w = '{addr: ADR_KEY_B, data: KEY_LO};
      default: w = sector ? '{addr: {sect, {SECT_LSB{1'b0}}}, data: GO_SECTOR}
                          : '{addr: ADR_KEY_A, data: GO_CHIP};
    endcase
    return w;
  endfunction

endpackage

// File: rtl/flash_bus_cycle.sv
module flash_bus_cycle
  import flash_erase_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 3,
  parameter int ACCESS_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] fl_addr_o,
  output logic [DATA_W-1:0] fl_wdata_o,
  output logic              fl_drive_o,
  input  logic [DATA_W-1:0] fl_rdata_i,
  output logic              fl_ce_no,
  output logic              fl_we_no,
  output logic              fl_oe_no
);

  localparam int MAX_CYC = (SETUP_CYC > PULSE_CYC) ?
                           ((SETUP_CYC > ACCESS_CYC) ? SETUP_CYC : ACCESS_CYC) :
                           ((PULSE_CYC > ACCESS_CYC) ? PULSE_CYC : ACCESS_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] SETUP_END  = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_END  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] ACCESS_END = CNT_W'(ACCESS_CYC - 1);

  bus_state_e        st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rdata_q;
  logic              ack_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= BUS_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      rdata_q <= '0;
      ack_q   <= 1'b0;
    end else begin
      ack_q <= 1'b0;
      unique case (st_q)
        BUS_IDLE: if (req_i) begin
          addr_q <= addr_i;
          data_q <= wdata_i;
          cnt_q  <= '0;
          st_q   <= wr_i ? BUS_SETUP : BUS_READ;
        end
        BUS_SETUP: if (cnt_q == SETUP_END) begin
          cnt_q <= '0;
          st_q  <= BUS_PULSE;
        end else cnt_q <= cnt_q + 1'b1;
        BUS_PULSE: if (cnt_q == PULSE_END) begin
          cnt_q <= '0;
          st_q  <= BUS_HOLD;
        end else cnt_q <= cnt_q + 1'b1;
        BUS_HOLD: begin
          ack_q <= 1'b1;
          st_q  <= BUS_IDLE;
        end
        BUS_READ: if (cnt_q == ACCESS_END) begin
          rdata_q <= fl_rdata_i;
          ack_q   <= 1'b1;
          cnt_q   <= '0;
          st_q    <= BUS_IDLE;
        end else cnt_q <= cnt_q + 1'b1;
        default: st_q <= BUS_IDLE;
      endcase
    end
  end

  assign ack_o      = ack_q;
  assign rdata_o    = rdata_q;
  assign fl_addr_o  = addr_q;
  assign fl_wdata_o = data_q;
  assign fl_drive_o = (st_q == BUS_SETUP) || (st_q == BUS_PULSE) || (st_q == BUS_HOLD);
  assign fl_ce_no   = (st_q == BUS_IDLE);
  assign fl_we_no   = (st_q != BUS_PULSE);
  assign fl_oe_no   = (st_q != BUS_READ);

endmodule

// File: rtl/flash_toggle_eval.sv
module flash_toggle_eval
  import flash_erase_pkg::*;
(
  input  logic [DATA_W-1:0] prev_i,
  input  logic [DATA_W-1:0] cur_i,
  output logic              settled_o,
  output logic              expired_o
);

  assign settled_o = (prev_i[BIT_TOGGLE] == cur_i[BIT_TOGGLE]);
  assign expired_o = cur_i[BIT_EXPIRED];

endmodule

// File: rtl/flash_erase_ctrl.sv
module flash_erase_ctrl
  import flash_erase_pkg::*;
#(
  parameter int POLL_LIMIT = 1000000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              sector_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic              bus_req_o,
  output logic              bus_wr_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic              bus_ack_i,
  input  logic [DATA_W-1:0] bus_rdata_i
);

  localparam int PC_W = $clog2(POLL_LIMIT + 1);
  localparam logic [PC_W-1:0] PC_MAX = PC_W'(POLL_LIMIT);

  ctl_state_e        st_q;
  logic [2:0]        step_q;
  logic              sector_q;
  logic [SECT_W-1:0] sect_q;
  logic [DATA_W-1:0] prev_q;
  logic              have_prev_q;
  logic              issued_q;
  logic [PC_W-1:0]   poll_cnt_q;
  logic [PC_W-1:0]   poll_cnt_nxt;
  logic              done_q;
  logic [DATA_W-1:0] result_q;
  logic              settled;
  logic              expired;
  logic              ceiling_hit;
  bus_word_t         cmd;

  flash_toggle_eval u_eval (
    .prev_i   (prev_q),
    .cur_i    (bus_rdata_i),
    .settled_o(settled),
    .expired_o(expired)
  );

  assign cmd          = cmd_word(step_q, sector_q, sect_q);
  assign poll_cnt_nxt = poll_cnt_q + 1'b1;
  assign ceiling_hit  = (poll_cnt_nxt >= PC_MAX);

  always_comb begin
    bus_req_o   = (st_q != CTL_IDLE) && !issued_q;
    bus_wr_o    = (st_q == CTL_CMD) || (st_q == CTL_RST);
    bus_addr_o  = ADR_KEY_A;
    bus_wdata_o = '0;
    if (st_q == CTL_CMD) begin
      bus_addr_o  = cmd.addr;
      bus_wdata_o = cmd.data;
    end else if (st_q == CTL_RST) begin
      bus_wdata_o = DEV_RESET;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= CTL_IDLE;
      step_q      <= '0;
      sector_q    <= 1'b0;
      sect_q      <= '0;
      prev_q      <= '0;
      have_prev_q <= 1'b0;
      issued_q    <= 1'b0;
      poll_cnt_q  <= '0;
      done_q      <= 1'b0;
      result_q    <= RES_PASS;
    end else begin
      done_q <= 1'b0;
      if (st_q == CTL_IDLE) begin
        if (start_i) begin
          sector_q <= sector_i;
          sect_q   <= addr_i[ADDR_W-1:SECT_LSB];
          step_q   <= '0;
          issued_q <= 1'b0;
          st_q     <= CTL_CMD;
        end
      end else begin
        if (bus_ack_i) issued_q <= 1'b0;
        else if (bus_req_o) issued_q <= 1'b1;

        if (bus_ack_i) begin
          unique case (st_q)
            CTL_CMD: begin
              if (step_q == 3'(CMD_LAST)) begin
                st_q        <= CTL_POLL;
                have_prev_q <= 1'b0;
                poll_cnt_q  <= '0;
              end else begin
                step_q <= step_q + 1'b1;
              end
            end
            CTL_POLL: begin
              poll_cnt_q <= poll_cnt_nxt;
              if (!have_prev_q) begin
                prev_q      <= bus_rdata_i;
                have_prev_q <= 1'b1;
                if (ceiling_hit) st_q <= CTL_RST;
              end else if (settled) begin
                st_q     <= CTL_IDLE;
                done_q   <= 1'b1;
                result_q <= RES_PASS;
              end else if (expired) begin
                st_q        <= CTL_RCHK;
                have_prev_q <= 1'b0;
              end else if (ceiling_hit) begin
                st_q <= CTL_RST;
              end else begin
                prev_q <= bus_rdata_i;
              end
            end
            CTL_RCHK: begin
              if (!have_prev_q) begin
                prev_q      <= bus_rdata_i;
                have_prev_q <= 1'b1;
              end else if (settled) begin
                st_q     <= CTL_IDLE;
                done_q   <= 1'b1;
                result_q <= RES_PASS;
              end else begin
                st_q <= CTL_RST;
              end
            end
            CTL_RST: begin
              st_q     <= CTL_IDLE;
              done_q   <= 1'b1;
              result_q <= RES_FAIL;
            end
            default: st_q <= CTL_IDLE;
          endcase
        end
      end
    end
  end

  assign busy_o   = (st_q != CTL_IDLE);
  assign done_o   = done_q;
  assign result_o = result_q;

endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
  import flash_erase_pkg::*;
#(
  parameter int SETUP_CYC  = 2,
  parameter int PULSE_CYC  = 3,
  parameter int ACCESS_CYC = 3,
  parameter int POLL_LIMIT = 1000000
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        sector_i,
  input  logic [19:0] addr_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [7:0]  result_o,
  output logic [19:0] fl_addr_o,
  inout  wire  [7:0]  fl_data_io,
  output logic        fl_ce_no,
  output logic        fl_we_no,
  output logic        fl_oe_no
);

  logic              bus_req;
  logic              bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic              bus_ack;
  logic [DATA_W-1:0] bus_rdata;
  logic [DATA_W-1:0] pin_wdata;
  logic              bus_drive;
  logic [DATA_W-1:0] pin_rdata;

  flash_erase_ctrl #(.POLL_LIMIT(POLL_LIMIT)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .sector_i   (sector_i),
    .addr_i     (addr_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o),
    .bus_req_o  (bus_req),
    .bus_wr_o   (bus_wr),
    .bus_addr_o (bus_addr),
    .bus_wdata_o(bus_wdata),
    .bus_ack_i  (bus_ack),
    .bus_rdata_i(bus_rdata)
  );

  flash_bus_cycle #(
    .SETUP_CYC (SETUP_CYC),
    .PULSE_CYC (PULSE_CYC),
    .ACCESS_CYC(ACCESS_CYC)
  ) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (bus_req),
    .wr_i      (bus_wr),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .ack_o     (bus_ack),
    .rdata_o   (bus_rdata),
    .fl_addr_o (fl_addr_o),
    .fl_wdata_o(pin_wdata),
    .fl_drive_o(bus_drive),
    .fl_rdata_i(pin_rdata),
    .fl_ce_no  (fl_ce_no),
    .fl_we_no  (fl_we_no),
    .fl_oe_no  (fl_oe_no)
  );

  assign pin_rdata = fl_data_io;

  for (genvar b = 0; b < DATA_W; b++) begin : g_pad
    assign fl_data_io[b] = bus_drive ? pin_wdata[b] : 1'bz;
  end

endmodule

// File: rtl/flash_erase_seq_chk.sv
module flash_erase_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [7:0]  result_o,
  input logic [19:0] fl_addr_o,
  input logic        fl_ce_no,
  input logic        fl_we_no,
  input logic        fl_oe_no,
  input logic        drv_en_i
);

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_DONE_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R10
  AST_RESULT_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (result_o == 8'h00 || result_o == 8'hFF)); // R5
  AST_NO_WE_OE_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!fl_we_no && !fl_oe_no)); // R3
  AST_WE_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_we_no |-> $stable(fl_addr_o)); // R3
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fl_oe_no |-> !drv_en_i); // R4
  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (fl_ce_no && fl_we_no && fl_oe_no)); // R12
  AST_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o); // R11

endmodule

bind flash_erase_seq flash_erase_seq_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .result_o (result_o),
  .fl_addr_o(fl_addr_o),
  .fl_ce_no (fl_ce_no),
  .fl_we_no (fl_we_no),
  .fl_oe_no (fl_oe_no),
  .drv_en_i (bus_drive)
);

// File: tb/flash_erase_seq_tb.sv
`timescale 1ns/1ps
module flash_erase_seq_tb;

  localparam int SETUP  = 2;
  localparam int PULSE  = 3;
  localparam int ACCESS = 2;
  localparam int LIMIT  = 32;
  localparam int NV     = 7;

  // op (1 = sector), address, toggling reads, first read with bit5 set (0 = never)
  localparam int          V_OP   [NV] = '{0, 1, 1, 0, 1, 0, 1};
  localparam logic [19:0] V_ADDR [NV] = '{20'h12345, 20'hABCDE, 20'hFFFFF, 20'h00000,
                                          20'h01234, 20'h55555, 20'h00FFF};
  localparam int          V_TOG  [NV] = '{5, 0, 9, 4, 100, 1000, 2};
  localparam int          V_TOAT [NV] = '{0, 0, 0, 3, 4, 0, 2};
  localparam int          V_RES  [NV] = '{8'h00, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hFF, 8'h00};
  localparam int          V_RD   [NV] = '{6, 2, 10, 5, 6, 32, 4};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        sector = 1'b0;
  logic [19:0] addr = '0;
  logic        busy, done;
  logic [7:0]  result;
  logic [19:0] fl_addr;
  wire  [7:0]  fl_data;
  logic        ce_n, we_n, oe_n;

  int n_chk = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  flash_erase_seq #(
    .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .ACCESS_CYC(ACCESS), .POLL_LIMIT(LIMIT)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .sector_i(sector), .addr_i(addr),
    .busy_o(busy), .done_o(done), .result_o(result),
    .fl_addr_o(fl_addr), .fl_data_io(fl_data),
    .fl_ce_no(ce_n), .fl_we_no(we_n), .fl_oe_no(oe_n)
  );

  // behavioural flash
  int          mdl_tog = 0;
  int          mdl_toat = 0;
  int          rd_k = 0;
  int          wr_n = 0;
  logic [19:0] wr_a [8];
  logic [7:0]  wr_d [8];
  logic [7:0]  mdl_val;

  always_comb begin
    mdl_val = 8'h00;
    mdl_val[6] = (rd_k <= mdl_tog) ? rd_k[0] : mdl_tog[0];
    mdl_val[5] = (mdl_toat > 0) && (rd_k >= mdl_toat);
  end

  assign fl_data = (!oe_n && !ce_n) ? mdl_val : 8'hzz;

  always @(negedge oe_n) rd_k++;

  always @(posedge we_n) begin
    if (!ce_n && wr_n < 8) begin
      wr_a[wr_n] = fl_addr;
      wr_d[wr_n] = fl_data;
      wr_n++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bus timing monitor
  int setup_run = 0;
  int pulse_run = 0;
  int acc_run = 0;
  bit prev_we = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!we_n) begin
        if (prev_we) chk(setup_run == SETUP, "R3", "setup cycles", setup_run, SETUP);
        pulse_run++;
      end else begin
        if (!prev_we) begin
          chk(pulse_run == PULSE, "R3", "we pulse cycles", pulse_run, PULSE);
          chk(!ce_n, "R3", "hold ce_n", int'(ce_n), 0);
          pulse_run = 0;
        end
        if (!ce_n && oe_n) setup_run++;
        else setup_run = 0;
      end
      if (!oe_n) acc_run++;
      else if (acc_run != 0) begin
        chk(acc_run == ACCESS, "R4", "oe access cycles", acc_run, ACCESS);
        acc_run = 0;
      end
      prev_we = we_n;
    end else begin
      setup_run = 0; pulse_run = 0; acc_run = 0; prev_we = 1'b1;
    end
  end

  function automatic logic [27:0] exp_wr(input int j, input int op, input logic [19:0] a);
    case (j)
      0: return {20'h05555, 8'hAA};
      1: return {20'h02AAA, 8'h55};
      2: return {20'h05555, 8'h80};
      3: return {20'h05555, 8'hAA};
      4: return {20'h02AAA, 8'h55};
      5: return (op != 0) ? {a[19:12], 12'h000, 8'h30} : {20'h05555, 8'h10};
      default: return {20'h05555, 8'hF0};
    endcase
  endfunction

  task automatic start_op(input int op, input logic [19:0] a, input int tog, input int toat);
    mdl_tog = tog; mdl_toat = toat; rd_k = 0; wr_n = 0;
    @(negedge clk);
    start = 1'b1; sector = op[0]; addr = a;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11", "busy after start", int'(busy), 1);
  endtask

  task automatic wait_done(output logic [7:0] res);
    int t = 0;
    while (!done && t < 5000) begin
      @(negedge clk);
      t++;
    end
    chk(done == 1'b1, "R10", "done seen", int'(done), 1);
    chk(busy == 1'b0, "R10", "busy low with done", int'(busy), 0);
    res = result;
    @(negedge clk);
    chk(done == 1'b0, "R10", "done one cycle", int'(done), 0);
    chk(result == res, "R10", "result held", result, res);
  endtask

  task automatic check_writes(input int op, input logic [19:0] a, input int nexp);
    chk(wr_n == nexp, (nexp == 7) ? "R8" : "R1", "write count", wr_n, nexp);
    for (int j = 0; j < nexp && j < wr_n; j++) begin
      logic [27:0] e;
      e = exp_wr(j, op, a);
      chk({wr_a[j], wr_d[j]} == e, (j == 6) ? "R8" : ((j == 5 && op != 0) ? "R2" : "R1"),
          "command write", {wr_a[j], wr_d[j]}, e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] res;
    // R12: reset state
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R12", "busy/done in reset", {busy, done}, 0);
    chk({ce_n, we_n, oe_n} == 3'b111, "R12", "strobes in reset", {ce_n, we_n, oe_n}, 7);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(result == 8'h00, "R12", "result after reset", result, 0);
    chk({ce_n, we_n, oe_n} == 3'b111, "R12", "strobes after reset", {ce_n, we_n, oe_n}, 7);

    // vector table: R5 R6 R7 R8 R9
    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = (V_TOAT[i] > 0) ? ((V_RES[i] != 0) ? "R8" : "R7") : ((V_RES[i] != 0) ? "R9" : "R5");
      start_op(V_OP[i], V_ADDR[i], V_TOG[i], V_TOAT[i]);
      wait_done(res);
      chk(res == V_RES[i][7:0], tg, "result code", res, V_RES[i]);
      chk(rd_k == V_RD[i], "R6", "status read count", rd_k, V_RD[i]);
      check_writes(V_OP[i], V_ADDR[i], (V_RES[i] != 0) ? 7 : 6);
    end

    // R11: start while busy ignored
    start_op(0, 20'h00000, 5, 0);
    repeat (15) @(negedge clk);
    start = 1'b1; sector = 1'b1; addr = 20'hFF000;
    @(negedge clk);
    start = 1'b0;
    wait_done(res);
    chk(res == 8'h00, "R11", "result unaffected", res, 0);
    check_writes(0, 20'h00000, 6);
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R11", "no second request", int'(busy), 0);
    chk(wr_n == 6, "R11", "no extra writes", wr_n, 6);

    // R12: reset in the middle of an erase
    start_op(1, 20'h3C000, 1000, 0);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R12", "busy/done after mid reset", {busy, done}, 0);
    chk({ce_n, we_n, oe_n} == 3'b111, "R12", "strobes after mid reset", {ce_n, we_n, oe_n}, 7);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(result == 8'h00, "R12", "result cleared", result, 0);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule